// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block keeps a set of hardware FIFO queues of descriptor addresses. It does not give each queue its own storage. All queues share one link memory that holds one next-pointer per descriptor index. Each queue keeps a head index, a tail index and an entry count in registers. A push appends the descriptor at the tail of its queue, and a pop unlinks the head and returns its address.

Descriptor addresses and link indices convert both ways through a small table of descriptor regions. Each region has a base address, a power-of-two descriptor size, a descriptor count and the link index of its first descriptor. A push address is converted to an index with a subtract, a shift and an add. An address that no region covers is dropped, and a one-cycle error pulse reports the drop.

The link memory is single-port. Every push or pop therefore runs a fixed two-cycle sequence, and a shared ready signal holds off new requests while a sequence is running. Besides push and pop, the block offers:
- a combinational peek at the count and head address of a selected queue;
- a non-empty status bit for every queue;
- an interrupt line for each queue of a contiguous interruptible subset.

Top module: `qm_desc_queue`

## Requirements
- R1: Descriptors pushed to one queue are popped from it in push order. Queues do not disturb each other, even when their pushes and pops are interleaved.
- R2: A pushed address A maps to the first region whose range holds it, at index ((A − base) >> size_log2) + start. A pop returns base + ((index − start) << size_log2). An address that is not aligned to its descriptor size therefore comes back rounded down to the descriptor start.
- R3: A push whose address no region holds changes no queue. It raises `drop_err` for one cycle, on the falling-edge sample after the second rising edge of the sequence.
- R4: A pop of an empty queue still sets `rsp_valid`, returns `rsp_addr` = 0 and leaves every queue unchanged.
- R5: A request is accepted on a rising edge where its valid and ready are both high. Both ready outputs are low in the cycle that follows. `rsp_valid` is high for exactly the cycle after the second rising edge.
- R6: When push and pop are both valid in the same idle cycle, `pop_ready` is low and the push goes first. A pop of the same queue that is held until ready then returns the pushed address.
- R7: `peek_count` gives the entry count of queue `peek_q`. `peek_addr` gives that queue's head address, or 0 when the queue is empty.
- R8: `q_nonempty[q]` is high exactly while queue q holds at least one entry. It changes only at the end of a push or pop sequence.
- R9: `irq[j]` follows `q_nonempty[IRQ_FIRST + j]` (default IRQ_FIRST = 4). It rises when that queue goes from zero to one entry, stays high while the queue is non-empty, and is never driven by other queues.
- R10: A write with `cfg_we` loads the region numbered `cfg_sel`. A region with count 0 holds no address. When two regions overlap, the lower-numbered region takes the address.
- R11: After reset all queues are empty, `irq` and `drop_err` are low, `rsp_valid` is low, and both ready signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | Push request |
| push_q | input | QID_W | Target queue of the push |
| push_addr | input | ADDR_W | Descriptor address to enqueue |
| push_ready | output | 1 | Push may be accepted this cycle |
| pop_valid | input | 1 | Pop request |
| pop_q | input | QID_W | Queue to pop |
| pop_ready | output | 1 | Pop may be accepted this cycle |
| rsp_valid | output | 1 | Pop response present |
| rsp_addr | output | ADDR_W | Popped descriptor address, 0 when the queue was empty |
| drop_err | output | 1 | Pulse: last push address belonged to no region |
| cfg_we | input | 1 | Region table write strobe |
| cfg_sel | input | RGN_W | Region number to write |
| cfg_base | input | ADDR_W | Region base address |
| cfg_size_log2 | input | SZ_W | Log2 of the descriptor size in bytes |
| cfg_count | input | CNT_W | Number of descriptors in the region |
| cfg_start | input | IDX_W | Link index of the first descriptor |
| peek_q | input | QID_W | Queue selected for peek |
| peek_count | output | CNT_W | Entry count of the peeked queue |
| peek_addr | output | ADDR_W | Head address of the peeked queue, 0 if empty |
| q_nonempty | output | NUM_Q | Per-queue non-empty status |
| irq | output | IRQ_NUM | Interrupt lines of the interruptible queues |

## Verification
Call the rising edge that accepts a request edge k. The ready outputs drop in the cycle after edge k. Queue state, status bits, interrupts, peek values, `rsp_valid`/`rsp_addr` and `drop_err` all change at edge k+1. The bench therefore holds each request for one edge and skips exactly one more rising edge. It then samples on the falling edge after edge k+1. Ready and `rsp_valid` are also sampled on the falling edge between edge k and edge k+1, which confirms that nothing arrives one cycle early.

// File: rtl/qm_pkg.sv
package qm_pkg;
  typedef enum logic [1:0] {
    QM_IDLE = 2'd0,
    QM_PUSH = 2'd1,
    QM_POP  = 2'd2
  } qm_state_e;
endpackage

// File: rtl/qm_link_ram.sv
// Single-port synchronous link memory: one next-index per descriptor.
module qm_link_ram #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [IDX_W-1:0] wdata,
  output logic [IDX_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/qm_region_table.sv
// Descriptor region table with address->index and index->address lookups.
module qm_region_table #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int NUM_RGN = 2,
  parameter int SZ_W    = 5,
  parameter int NUM_RD  = 2,
  localparam int CNT_W  = IDX_W + 1,
  localparam int RGN_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [RGN_W-1:0]              cfg_sel,
  input  logic [ADDR_W-1:0]             cfg_base,
  input  logic [SZ_W-1:0]               cfg_size_log2,
  input  logic [CNT_W-1:0]              cfg_count,
  input  logic [IDX_W-1:0]              cfg_start,
  input  logic [ADDR_W-1:0]             fwd_addr,
  output logic                          fwd_hit,
  output logic [IDX_W-1:0]              fwd_idx,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rev_idx,
  output logic [NUM_RD-1:0][ADDR_W-1:0] rev_addr
);
  logic [NUM_RGN-1:0][ADDR_W-1:0] base_r;
  logic [NUM_RGN-1:0][SZ_W-1:0]   size_r;
  logic [NUM_RGN-1:0][CNT_W-1:0]  cnt_r;
  logic [NUM_RGN-1:0][IDX_W-1:0]  start_r;

  logic [NUM_RGN-1:0]             f_hit;
  logic [NUM_RGN-1:0][IDX_W-1:0]  f_idx;

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    logic wr_en;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] slot;

    assign wr_en = cfg_we && (cfg_sel == RGN_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_r[r]  <= '0;
        size_r[r]  <= '0;
        cnt_r[r]   <= '0;
        start_r[r] <= '0;
      end else if (wr_en) begin
        base_r[r]  <= cfg_base;
        size_r[r]  <= cfg_size_log2;
        cnt_r[r]   <= cfg_count;
        start_r[r] <= cfg_start;
      end
    end

    assign off      = fwd_addr - base_r[r];
    assign slot     = off >> size_r[r];
    assign f_hit[r] = (fwd_addr >= base_r[r]) && (slot < ADDR_W'(cnt_r[r]));
    assign f_idx[r] = slot[IDX_W-1:0] + start_r[r];
  end

  // Lowest-numbered matching region wins.
  always_comb begin
    fwd_hit = 1'b0;
    fwd_idx = '0;
    for (int r = NUM_RGN - 1; r >= 0; r--) begin
      if (f_hit[r]) begin
        fwd_hit = 1'b1;
        fwd_idx = f_idx[r];
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rev
    logic [NUM_RGN-1:0]             r_hit;
    logic [NUM_RGN-1:0][ADDR_W-1:0] r_addr;

    for (genvar r = 0; r < NUM_RGN; r++) begin : g_cand
      logic [CNT_W-1:0] rel;
      assign rel         = {1'b0, rev_idx[p]} - {1'b0, start_r[r]};
      assign r_hit[r]    = (rev_idx[p] >= start_r[r]) && (rel < cnt_r[r]);
      assign r_addr[r]   = base_r[r] + (ADDR_W'(rel) << size_r[r]);
    end

    always_comb begin
      rev_addr[p] = '0;
      for (int r = NUM_RGN - 1; r >= 0; r--) begin
        if (r_hit[r]) rev_addr[p] = r_addr[r];
      end
    end
  end
endmodule

// File: rtl/qm_qstate.sv
// Per-queue head, tail and count registers with one update port.
module qm_qstate #(
  parameter int NUM_Q  = 8,
  parameter int IDX_W  = 6,
  localparam int QID_W = $clog2(NUM_Q),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          upd_en,
  input  logic [QID_W-1:0]              upd_q,
  input  logic                          set_head,
  input  logic [IDX_W-1:0]              head_val,
  input  logic                          set_tail,
  input  logic [IDX_W-1:0]              tail_val,
  input  logic                          cnt_inc,
  input  logic                          cnt_dec,
  output logic [NUM_Q-1:0][IDX_W-1:0]   head_o,
  output logic [NUM_Q-1:0][IDX_W-1:0]   tail_o,
  output logic [NUM_Q-1:0][CNT_W-1:0]   cnt_o
);
  logic [NUM_Q-1:0][IDX_W-1:0] head_r, head_n;
  logic [NUM_Q-1:0][IDX_W-1:0] tail_r, tail_n;
  logic [NUM_Q-1:0][CNT_W-1:0] cnt_r, cnt_n;

  always_comb begin
    head_n = head_r;
    tail_n = tail_r;
    cnt_n  = cnt_r;
    if (set_head) head_n[upd_q] = head_val;
    if (set_tail) tail_n[upd_q] = tail_val;
    cnt_n[upd_q] = cnt_r[upd_q] + CNT_W'(cnt_inc) - CNT_W'(cnt_dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_r <= '0;
      tail_r <= '0;
      cnt_r  <= '0;
    end else if (upd_en) begin
      head_r <= head_n;
      tail_r <= tail_n;
      cnt_r  <= cnt_n;
    end
  end

  assign head_o = head_r;
  assign tail_o = tail_r;
  assign cnt_o  = cnt_r;
endmodule

// File: rtl/qm_desc_queue.sv
module qm_desc_queue #(
  parameter int NUM_Q     = 8,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 6,
  parameter int NUM_RGN   = 2,
  parameter int SZ_W      = 5,
  parameter int IRQ_FIRST = 4,
  parameter int IRQ_NUM   = 4,
  localparam int QID_W    = $clog2(NUM_Q),
  localparam int CNT_W    = IDX_W + 1,
  localparam int RGN_W    = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic [QID_W-1:0]   push_q,
  input  logic [ADDR_W-1:0]  push_addr,
  output logic               push_ready,
  input  logic               pop_valid,
  input  logic [QID_W-1:0]   pop_q,
  output logic               pop_ready,
  output logic               rsp_valid,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic               drop_err,
  input  logic               cfg_we,
  input  logic [RGN_W-1:0]   cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [SZ_W-1:0]    cfg_size_log2,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic [IDX_W-1:0]   cfg_start,
  input  logic [QID_W-1:0]   peek_q,
  output logic [CNT_W-1:0]   peek_count,
  output logic [ADDR_W-1:0]  peek_addr,
  output logic [NUM_Q-1:0]   q_nonempty,
  output logic [IRQ_NUM-1:0] irq
);
  import qm_pkg::*;

  // Reset: asserts asynchronously, releases on the clock.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  qm_state_e          state_r, state_n;
  logic [QID_W-1:0]   opq_r, opq_n;
  logic [IDX_W-1:0]   opidx_r, opidx_n;
  logic               ophit_r, ophit_n;
  logic               rsp_valid_r, drop_r;
  logic [ADDR_W-1:0]  rsp_addr_r, rsp_addr_n;

  logic [NUM_Q-1:0][IDX_W-1:0] head_w, tail_w;
  logic [NUM_Q-1:0][CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0]            cur_cnt;
  logic                        cur_empty;

  logic                        fwd_hit;
  logic [IDX_W-1:0]            fwd_idx;
  logic [1:0][IDX_W-1:0]       rev_idx;
  logic [1:0][ADDR_W-1:0]      rev_addr;

  logic                        ram_en, ram_we;
  logic [IDX_W-1:0]            ram_addr, ram_rdata;

  logic                        upd_en, set_head, cnt_inc, cnt_dec;
  logic [IDX_W-1:0]            head_val;

  logic idle, acc_push, acc_pop, in_push, in_pop;

  assign idle       = (state_r == QM_IDLE) && rst_sync_n;
  assign push_ready = idle;
  assign pop_ready  = idle && !push_valid;
  assign acc_push   = push_valid && push_ready;
  assign acc_pop    = pop_valid && pop_ready;
  assign in_push    = (state_r == QM_PUSH);
  assign in_pop     = (state_r == QM_POP);

  assign cur_cnt    = cnt_w[opq_r];
  assign cur_empty  = (cur_cnt == '0);

  // Link memory port: pop reads next-of-head at accept, push links old tail.
  assign ram_en   = acc_pop || (in_push && ophit_r && !cur_empty);
  assign ram_we   = in_push;
  assign ram_addr = acc_pop ? head_w[pop_q] : tail_w[opq_r];

  // Queue state update at the end of each sequence.
  assign upd_en   = (in_push && ophit_r) || (in_pop && !cur_empty);
  assign set_head = in_pop || (in_push && cur_empty);
  assign head_val = in_pop ? ram_rdata : opidx_r;
  assign cnt_inc  = in_push;
  assign cnt_dec  = in_pop;

  assign rev_idx[0] = head_w[opq_r];
  assign rev_idx[1] = head_w[peek_q];

  always_comb begin
    state_n = state_r;
    opq_n   = opq_r;
    opidx_n = opidx_r;
    ophit_n = ophit_r;
    case (state_r)
      QM_IDLE: begin
        if (acc_push) begin
          state_n = QM_PUSH;
          opq_n   = push_q;
          opidx_n = fwd_idx;
          ophit_n = fwd_hit;
        end else if (acc_pop) begin
          state_n = QM_POP;
          opq_n   = pop_q;
        end
      end
      default: state_n = QM_IDLE;
    endcase
  end

  assign rsp_addr_n = cur_empty ? '0 : rev_addr[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_r     <= QM_IDLE;
      opq_r       <= '0;
      opidx_r     <= '0;
      ophit_r     <= 1'b0;
      rsp_valid_r <= 1'b0;
      drop_r      <= 1'b0;
      rsp_addr_r  <= '0;
    end else begin
      state_r     <= state_n;
      rsp_valid_r <= in_pop;
      drop_r      <= in_push && !ophit_r;
      if (idle) begin
        opq_r   <= opq_n;
        opidx_r <= opidx_n;
        ophit_r <= ophit_n;
      end
      if (in_pop) rsp_addr_r <= rsp_addr_n;
    end
  end

  qm_region_table #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_RGN(NUM_RGN), .SZ_W(SZ_W), .NUM_RD(2)
  ) rgn_i (
    .clk(clk), .rst_n(rst_sync_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
    .cfg_size_log2(cfg_size_log2), .cfg_count(cfg_count), .cfg_start(cfg_start),
    .fwd_addr(push_addr), .fwd_hit(fwd_hit), .fwd_idx(fwd_idx),
    .rev_idx(rev_idx), .rev_addr(rev_addr)
  );

  qm_link_ram #(.IDX_W(IDX_W)) link_i (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(opidx_r), .rdata(ram_rdata)
  );

  qm_qstate #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) qs_i (
    .clk(clk), .rst_n(rst_sync_n), .upd_en(upd_en), .upd_q(opq_r),
    .set_head(set_head), .head_val(head_val),
    .set_tail(in_push), .tail_val(opidx_r),
    .cnt_inc(cnt_inc), .cnt_dec(cnt_dec),
    .head_o(head_w), .tail_o(tail_w), .cnt_o(cnt_w)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_stat
    assign q_nonempty[q] = (cnt_w[q] != '0);
  end

  for (genvar j = 0; j < IRQ_NUM; j++) begin : g_irq
    assign irq[j] = q_nonempty[IRQ_FIRST + j];
  end

  assign peek_count = cnt_w[peek_q];
  assign peek_addr  = (cnt_w[peek_q] == '0) ? '0 : rev_addr[1];
  assign rsp_valid  = rsp_valid_r;
  assign rsp_addr   = rsp_addr_r;
  assign drop_err   = drop_r;
endmodule

// File: rtl/qm_desc_queue_chk.sv
module qm_desc_queue_chk #(
  parameter int NUM_Q = 8,
  parameter int CNT_W = 7
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        push_valid,
  input logic                        push_ready,
  input logic                        pop_valid,
  input logic                        pop_ready,
  input logic                        rsp_valid,
  input logic                        drop_err,
  input logic [NUM_Q-1:0]            q_nonempty,
  input qm_pkg::qm_state_e           state,
  input logic [NUM_Q-1:0][CNT_W-1:0] cnt
);
  import qm_pkg::*;

  // R5
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((push_valid && push_ready) || (pop_valid && pop_ready)) |=> (!push_ready && !pop_ready));

  // R5
  rsp_two_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready) |=> ##1 rsp_valid);

  // R6
  push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_valid && push_ready) |=> (state == QM_PUSH));

  // R3
  drop_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |-> ($past(state) == QM_PUSH));

  // R1
  idle_count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == QM_IDLE) |=> $stable(cnt));

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    // R8
    nonempty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_nonempty[q]) |-> ($past(state) == QM_PUSH));
    // R8
    nonempty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q_nonempty[q]) |-> ($past(state) == QM_POP));
  end
endmodule

bind qm_desc_queue qm_desc_queue_chk #(.NUM_Q(NUM_Q), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n),
  .push_valid(push_valid), .push_ready(push_ready),
  .pop_valid(pop_valid), .pop_ready(pop_ready),
  .rsp_valid(rsp_valid), .drop_err(drop_err),
  .q_nonempty(q_nonempty), .state(state_r), .cnt(cnt_w)
);

// File: tb/qm_desc_queue_tb_top.sv
module qm_desc_queue_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        is_pop;
    logic [2:0]  q;
    logic [31:0] addr;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  // R1 R2 R4: interleaved traffic on queues 1 and 2.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 3'd1, 32'h1000_0000, 32'h0},
    '{1'b0, 3'd1, 32'h2000_0180, 32'h0},
    '{1'b0, 3'd2, 32'h1000_0080, 32'h0},
    '{1'b0, 3'd1, 32'h1000_0044, 32'h0},
    '{1'b1, 3'd1, 32'h0,         32'h1000_0000},
    '{1'b1, 3'd2, 32'h0,         32'h1000_0080},
    '{1'b1, 3'd1, 32'h0,         32'h2000_0180},
    '{1'b0, 3'd2, 32'h2000_0380, 32'h0},
    '{1'b1, 3'd1, 32'h0,         32'h1000_0040},
    '{1'b1, 3'd1, 32'h0,         32'h0},
    '{1'b1, 3'd2, 32'h0,         32'h2000_0380},
    '{1'b1, 3'd2, 32'h0,         32'h0}
  };

  logic        clk, rst_n;
  logic        push_valid, push_ready, pop_valid, pop_ready;
  logic [2:0]  push_q, pop_q, peek_q;
  logic [31:0] push_addr, rsp_addr, peek_addr, cfg_base;
  logic        rsp_valid, drop_err, cfg_we;
  logic [0:0]  cfg_sel;
  logic [4:0]  cfg_size_log2;
  logic [6:0]  cfg_count, peek_count;
  logic [5:0]  cfg_start;
  logic [7:0]  q_nonempty;
  logic [3:0]  irq;

  int checks, failures;

  qm_desc_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_q(push_q), .push_addr(push_addr), .push_ready(push_ready),
    .pop_valid(pop_valid), .pop_q(pop_q), .pop_ready(pop_ready),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .drop_err(drop_err),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2),
    .cfg_count(cfg_count), .cfg_start(cfg_start),
    .peek_q(peek_q), .peek_count(peek_count), .peek_addr(peek_addr),
    .q_nonempty(q_nonempty), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_region(input logic s, input logic [31:0] b, input logic [4:0] sz,
                            input logic [6:0] n, input logic [5:0] st);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_base = b; cfg_size_log2 = sz; cfg_count = n; cfg_start = st;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Ends on the falling edge after the second rising edge.
  task automatic do_push(input logic [2:0] q, input logic [31:0] a);
    @(negedge clk);
    push_valid = 1'b1; push_q = q; push_addr = a;
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_pop(input logic [2:0] q, output logic v, output logic [31:0] a);
    @(negedge clk);
    pop_valid = 1'b1; pop_q = q;
    @(posedge clk);
    @(negedge clk);
    pop_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    v = rsp_valid; a = rsp_addr;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; failures++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic        v;
    logic [31:0] a;
    checks = 0; failures = 0;
    rst_n = 1'b0;
    push_valid = 0; pop_valid = 0; push_q = 0; pop_q = 0; push_addr = 0;
    cfg_we = 0; cfg_sel = 0; cfg_base = 0; cfg_size_log2 = 0; cfg_count = 0; cfg_start = 0;
    peek_q = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 push_ready", push_ready, 1);
    check("R11 pop_ready", pop_ready, 1);
    check("R11 q_nonempty", q_nonempty, 0);
    check("R11 irq", irq, 0);
    check("R11 rsp_valid", rsp_valid, 0);
    check("R11 drop_err", drop_err, 0);
    check("R11 peek_addr", peek_addr, 0);

    // R10 regions: 64-byte x16 from index 0, 128-byte x8 from index 16
    cfg_region(1'b0, 32'h1000_0000, 5'd6, 7'd16, 6'd0);
    cfg_region(1'b1, 32'h2000_0000, 5'd7, 7'd8, 6'd16);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].is_pop) begin
        do_pop(VECS[i].q, v, a);
        check($sformatf("R1 R2 R4 vec%0d rsp_valid", i), v, 1);
        check($sformatf("R1 R2 R4 vec%0d rsp_addr", i), a, VECS[i].exp);
      end else begin
        do_push(VECS[i].q, VECS[i].addr);
        check($sformatf("R2 vec%0d drop_err", i), drop_err, 0);
      end
    end
    check("R8 all empty after table", q_nonempty, 0);

    // R5 ready and response timing
    @(negedge clk);
    pop_valid = 1'b1; pop_q = 3'd0;
    @(posedge clk);
    @(negedge clk);
    pop_valid = 1'b0;
    check("R5 push_ready busy", push_ready, 0);
    check("R5 pop_ready busy", pop_ready, 0);
    check("R5 rsp early", rsp_valid, 0);
    @(posedge clk);
    @(negedge clk);
    check("R5 rsp due", rsp_valid, 1);
    check("R4 empty pop addr", rsp_addr, 0);
    check("R5 ready back", push_ready, 1);
    @(negedge clk);
    check("R5 rsp one cycle", rsp_valid, 0);

    // R3 unmapped addresses
    do_push(3'd3, 32'h3000_0000);
    check("R3 drop no region", drop_err, 1);
    check("R3 queue untouched", q_nonempty[3], 0);
    @(negedge clk);
    check("R3 drop pulse ends", drop_err, 0);
    do_push(3'd3, 32'h1000_0400);
    check("R3 drop beyond count", drop_err, 1);
    peek_q = 3'd3;
    #1 check("R3 count zero", peek_count, 0);

    // R7 R9 peek and interrupt on queue 6 (irq line 2)
    do_push(3'd6, 32'h1000_0200);
    check("R9 irq rises", irq, 4'b0100);
    do_push(3'd6, 32'h2000_0100);
    peek_q = 3'd6;
    #1;
    check("R7 peek count", peek_count, 2);
    check("R7 peek head", peek_addr, 32'h1000_0200);
    check("R8 nonempty q6", q_nonempty, 8'h40);
    do_pop(3'd6, v, a);
    check("R1 q6 first", a, 32'h1000_0200);
    #1;
    check("R7 peek after pop", peek_addr, 32'h2000_0100);
    check("R9 irq held", irq, 4'b0100);
    do_pop(3'd6, v, a);
    check("R1 q6 second", a, 32'h2000_0100);
    check("R9 irq falls", irq, 0);

    // R6 simultaneous push and pop on empty queue 5 (irq line 1)
    @(negedge clk);
    push_valid = 1'b1; push_q = 3'd5; push_addr = 32'h1000_0100;
    pop_valid = 1'b1; pop_q = 3'd5;
    #1;
    check("R6 push_ready", push_ready, 1);
    check("R6 pop held", pop_ready, 0);
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 irq q5", irq, 4'b0010);
    check("R6 pop ready now", pop_ready, 1);
    @(posedge clk);
    @(negedge clk);
    pop_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6 rsp_valid", rsp_valid, 1);
    check("R6 pop sees push", rsp_addr, 32'h1000_0100);
    check("R9 irq q5 clear", irq, 0);

    // R10 overlap: region 1 covers region 0 with 128-byte slots; region 0 wins
    cfg_region(1'b1, 32'h1000_0000, 5'd7, 7'd8, 6'd32);
    do_push(3'd0, 32'h1000_0040);
    peek_q = 3'd0;
    #1 check("R10 lower region wins", peek_addr, 32'h1000_0040);
    do_pop(3'd0, v, a);
    check("R10 overlap pop", a, 32'h1000_0040);
    // R10 zero-count region holds nothing
    cfg_region(1'b1, 32'h3000_0000, 5'd7, 7'd0, 6'd40);
    do_push(3'd3, 32'h3000_0000);
    check("R10 zero count drops", drop_err, 1);
    check("R10 queue3 empty", q_nonempty, 0);

    finish_run();
  end
endmodule